// File: doc/BRIEF.md
# Multi-Mode Self-Test Register

This block is a bank of flip-flops, three wide by default, that sits on the path between two pieces of combinational logic and can take on one of four roles. As a functional register it captures its parallel input on every edge. As a scan chain it shifts serially, so a tester can read its contents out and write new contents in. As a pattern source it runs as a linear feedback shift register and drives pseudo-random stimulus into the logic downstream. As a response compactor it folds the parallel data arriving from the logic upstream into a running signature.

At the end of a compaction run the signature is compared with an expected value supplied at a port, and a match flag reports the result. A seed-load input writes the parallel input into the register in any mode. This is how a generator is started from a known state or a compactor is preset. Mode selection is registered, so the block changes role one edge after the select changes.

Top module: `mtr_top`

## Requirements
- R1: A synchronous reset (rst high at an edge) sets every register bit to 1 and the registered mode to functional (00). After reset the match flag is 0 and scan_out is 1.
- R2: In functional mode (00), with seed_load low, the register captures par_in at every edge, and par_out shows the captured value.
- R3: In scan mode (01), with seed_load low, each edge shifts the register toward the MSB: bit 0 takes scan_in and bit i takes old bit i-1. scan_out always shows the register MSB, and par_in has no effect.
- R4: In pattern mode (10), with seed_load low, each edge shifts the register left and the new bit 0 is the XOR of the tapped bits. The default taps are bits 2 and 0. From 111 the 3-bit sequence is 111, 110, 101, 010, 100, 001, 011, after which it returns to 111.
- R5: In pattern mode a non-zero state never steps to 000, and the default 3-bit sequence has period 7.
- R6: In signature mode (11), with seed_load low, the next state is the pattern-mode next state XORed bit by bit with par_in.
- R7: The mode select is registered. The value of mode_sel at edge k decides the register operation at edge k+1. The operation at edge k still uses the previously registered mode.
- R8: seed_load high writes par_in into the register in any registered mode and takes priority over that mode's operation.
- R9: A seed_load of all zeros while the registered mode is pattern writes all ones. In any other mode, all zeros is written as given.
- R10: match is combinational. It is 1 exactly when the registered mode is signature and the register equals exp_sig, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Requested mode: 00 functional, 01 scan, 10 pattern, 11 signature |
| seed_load | input | 1 | Write par_in into the register this edge |
| par_in | input | WIDTH | Parallel functional / response / seed data |
| scan_in | input | 1 | Serial data into bit 0 in scan mode |
| exp_sig | input | WIDTH | Expected signature for comparison |
| par_out | output | WIDTH | Register contents |
| scan_out | output | 1 | Register MSB |
| match | output | 1 | Signature equals exp_sig in signature mode |

## Verification
The bench targets the one-edge lag of the mode select. A design that applied the new mode immediately would run a pattern step where a functional capture belongs. The bench loads an all-zero seed in pattern mode and again in other modes. A missing substitution would lock the generator at zero, and an overly broad one would corrupt ordinary loads. It walks the full seven-state generator cycle, where a wrong tap would break the sequence or shorten the period. It also checks the match flag just after the block leaves signature mode, where a flag that ignored the mode would report a false pass.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    typedef enum logic [1:0] {
        MODE_FUNC    = 2'b00,
        MODE_SHIFT   = 2'b01,
        MODE_GEN     = 2'b10,
        MODE_COMPACT = 2'b11
    } mtr_mode_e;

    typedef struct packed {
        mtr_mode_e mode;
        logic      load;
    } mtr_ctl_t;

endpackage

// File: rtl/mtr_mode_ctl.sv
module mtr_mode_ctl
    import mtr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  mtr_mode_e mode_in,
    output mtr_mode_e mode_q
);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_FUNC;
        else     mode_q <= mode_in;
    end

    // R7
    mode_lag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mode_q == $past(mode_in)));

endmodule

// File: rtl/mtr_feedback.sv
module mtr_feedback #(
    parameter int          WIDTH = 3,
    parameter logic [WIDTH-1:0] TAPS = 3'b101
) (
    input  logic [WIDTH-1:0] state,
    output logic             fb
);

    always_comb fb = ^(state & TAPS);

endmodule

// File: rtl/mtr_cell.sv
module mtr_cell
    import mtr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mtr_ctl_t ctl,
    input  logic     seed_bit,
    input  logic     func_bit,
    input  logic     prev_bit,
    output logic     q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b1;
        end else if (ctl.load) begin
            q <= seed_bit;
        end else begin
            unique case (ctl.mode)
                MODE_FUNC:    q <= func_bit;
                MODE_SHIFT:   q <= prev_bit;
                MODE_GEN:     q <= prev_bit;
                MODE_COMPACT: q <= prev_bit ^ func_bit;
            endcase
        end
    end

endmodule

// File: rtl/mtr_sig_cmp.sv
module mtr_sig_cmp
    import mtr_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] state,
    input  logic [WIDTH-1:0] expected,
    input  mtr_mode_e        mode,
    output logic             match
);

    always_comb match = (mode == MODE_COMPACT) && (state == expected);

endmodule

// File: rtl/mtr_top.sv
module mtr_top
    import mtr_pkg::*;
#(
    parameter int               WIDTH = 3,
    parameter logic [WIDTH-1:0] TAPS  = 3'b101
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    input  logic [WIDTH-1:0] exp_sig,
    output logic [WIDTH-1:0] par_out,
    output logic             scan_out,
    output logic             match
);

    localparam int MSB = WIDTH - 1;

    mtr_mode_e        mode_q;
    mtr_ctl_t         ctl;
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] prev;
    logic [WIDTH-1:0] seed;
    logic             fb;

    mtr_mode_ctl u_mode (
        .clk     (clk),
        .rst     (rst),
        .mode_in (mtr_mode_e'(mode_sel)),
        .mode_q  (mode_q)
    );

    mtr_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
        .state (q),
        .fb    (fb)
    );

    always_comb begin
        ctl.mode = mode_q;
        ctl.load = seed_load;
        if (mode_q == MODE_GEN && par_in == '0) seed = '1;
        else                                    seed = par_in;
    end

    always_comb prev[0] = (mode_q == MODE_SHIFT) ? scan_in : fb;

    for (genvar i = 1; i < WIDTH; i++) begin : g_chain
        always_comb prev[i] = q[i-1];
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        mtr_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .ctl      (ctl),
            .seed_bit (seed[i]),
            .func_bit (par_in[i]),
            .prev_bit (prev[i]),
            .q        (q[i])
        );
    end

    mtr_sig_cmp #(.WIDTH(WIDTH)) u_cmp (
        .state    (q),
        .expected (exp_sig),
        .mode     (mode_q),
        .match    (match)
    );

    always_comb begin
        par_out  = q;
        scan_out = q[MSB];
    end

    // R2
    func_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FUNC && !seed_load) |=> (q == $past(par_in)));

    // R3
    scan_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SHIFT && !seed_load) |=> (q == {$past(q[MSB-1:0]), $past(scan_in)}));

    // R5
    gen_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_GEN && !seed_load && q != '0) |=> (q != '0));

    // R6
    compact_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_COMPACT && !seed_load) |=>
        (q == ({$past(q[MSB-1:0]), $past(fb)} ^ $past(par_in))));

    // R8
    seed_write_chk: assert property (@(posedge clk) disable iff (rst)
        (seed_load && par_in != '0) |=> (q == $past(par_in)));

    // R9
    zero_seed_chk: assert property (@(posedge clk) disable iff (rst)
        (seed_load && par_in == '0 && mode_q == MODE_GEN) |=> (q == '1));

    // R10
    match_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_COMPACT) |-> !match);

endmodule

// File: tb/sim_mtr_top.sv
module sim_mtr_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode_sel;
    logic       seed_load;
    logic [2:0] par_in;
    logic       scan_in;
    logic [2:0] exp_sig;
    logic [2:0] par_out;
    logic       scan_out;
    logic       match;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    mtr_top u0 (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .seed_load(seed_load),
        .par_in   (par_in),
        .scan_in  (scan_in),
        .exp_sig  (exp_sig),
        .par_out  (par_out),
        .scan_out (scan_out),
        .match    (match)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] sig_model(input logic [2:0] s, input logic [2:0] d);
        return {s[1:0], s[2] ^ s[0]} ^ d;
    endfunction

    task automatic t_reset();
        rst = 1; mode_sel = 2'b11; seed_load = 0; par_in = 0; scan_in = 0; exp_sig = 3'b111;
        tick(); tick();
        rst = 0; mode_sel = 2'b00; par_in = 3'b010;
        #1;
        chk("R1 par_out", par_out, 7);
        chk("R1 scan_out", scan_out, 1);
        chk("R1 match", match, 0);
    endtask

    task automatic t_func();
        logic [2:0] vals [4] = '{3'd5, 3'd2, 3'd0, 3'd7};
        mode_sel = 2'b00; seed_load = 0;
        foreach (vals[i]) begin
            par_in = vals[i];
            tick();
            chk("R2 capture", par_out, vals[i]);
        end
    endtask

    task automatic t_mode_lag();
        mode_sel = 2'b00; par_in = 3'd3; tick();
        mode_sel = 2'b10; par_in = 3'd4; tick();
        chk("R7 old mode at switch edge", par_out, 4);
        par_in = 3'd6; tick();
        chk("R7 new mode next edge", par_out, 1);
    endtask

    task automatic t_scan();
        logic [4:0] bits = 5'b01101;
        logic [2:0] ref_q;
        mode_sel = 2'b00; par_in = 0; tick();
        mode_sel = 2'b01; tick();
        ref_q = 0;
        par_in = 3'd7;
        for (int i = 0; i < 5; i++) begin
            scan_in = bits[i];
            tick();
            ref_q = {ref_q[1:0], bits[i]};
            chk("R3 shift", par_out, ref_q);
            chk("R3 scan_out", scan_out, ref_q[2]);
        end
        scan_in = 0;
    endtask

    task automatic t_pattern();
        logic [2:0] seq [8] = '{3'd7, 3'd6, 3'd5, 3'd2, 3'd4, 3'd1, 3'd3, 3'd7};
        mode_sel = 2'b10; seed_load = 1; par_in = 3'd7; tick();
        seed_load = 0; par_in = 3'd0; tick();
        chk("R4 seeded step", par_out, seq[1]);
        for (int i = 2; i < 8; i++) begin
            tick();
            chk(i == 7 ? "R5 period 7" : "R4 sequence", par_out, seq[i]);
        end
    endtask

    task automatic t_seed();
        mode_sel = 2'b01; seed_load = 0; tick();
        seed_load = 1; par_in = 3'd5; tick();
        chk("R8 load in scan mode", par_out, 5);
        mode_sel = 2'b10; seed_load = 0; tick();
        seed_load = 1; par_in = 3'd0; tick();
        chk("R9 zero seed in pattern", par_out, 7);
        mode_sel = 2'b00; seed_load = 0; par_in = 3'd2; tick();
        seed_load = 1; par_in = 3'd0; tick();
        chk("R9 zero seed in functional", par_out, 0);
        seed_load = 0;
    endtask

    task automatic t_signature();
        logic [2:0] resp [4] = '{3'd3, 3'd5, 3'd0, 3'd6};
        logic [2:0] ref_q;
        mode_sel = 2'b11; seed_load = 1; par_in = 3'd7; tick();
        seed_load = 0;
        ref_q = 3'd7;
        chk("R8 preset", par_out, 7);
        foreach (resp[i]) begin
            par_in = resp[i];
            tick();
            ref_q = sig_model(ref_q, resp[i]);
            chk("R6 compaction", par_out, ref_q);
        end
        exp_sig = ref_q; #1;
        chk("R10 match equal", match, 1);
        exp_sig = ref_q ^ 3'd4; #1;
        chk("R10 match unequal", match, 0);
        mode_sel = 2'b00; par_in = 3'd6; tick();
        ref_q = sig_model(ref_q, 3'd6);
        chk("R7 still compacting at switch edge", par_out, ref_q);
        exp_sig = ref_q; #1;
        chk("R10 no match outside signature mode", match, 0);
    endtask

    initial begin
        t_reset();
        t_func();
        t_mode_lag();
        t_scan();
        t_pattern();
        t_seed();
        t_signature();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule